// File: doc/BRIEF.md
# Stereo PWM Audio Output Stage

This block takes 16-bit PCM audio samples and produces one pulse-width-modulated bit per channel, for left and right. An external low-pass filter on each output then recovers the analog signal. A small register bus (write strobe, address, write data, read data) reaches two words: a sample word at offset 0x00 and a control word at offset 0x04.

A write to the sample word places one stereo pair, or one mono sample copied to both channels, into a one-entry holding register. `smp_ready_o` is high while that register is empty. The held pair moves into the active PWM generators only at a sample boundary, that is, after the programmed number of PWM periods has run out. While output is disabled it moves on the next clock. If no new pair has arrived by the boundary, the active pair is played again.

The control word sets the enable, the period length (256 or 1024 clocks), the pulse placement within the period, the number of periods each sample is held, an optional MSB flip for two's-complement input, and a left shift of 0 to 7 bits applied before the comparison.

Top module: `pwm_audio_dac`

## Requirements
- R1: After reset, reading offset 0x04 returns 0x0000_4008: disabled, 8-bit period, centred pulse, one period per sample, MSB flip on, shift 0, change flag 0. Reading offset 0x00 always returns 0. `pwm_o` is 0 and `smp_ready_o` is 1.
- R2: A write to offset 0x04 stores bits 17:0. Bit 13 is a change flag that is only stored. A later read returns the stored bits, with bits 31:18 reading as 0.
- R3: While control bit 0 is 0, both outputs are 0 from the second clock after the disabling write. Setting bit 0 starts a fresh period at count 0: the output for count 0 appears on the second clock edge after the enabling write.
- R4: When control bit 1 is 0 the period is 256 clocks and the duty `d` is bits 15:8 of the processed sample. When bit 1 is 1 the period is 1024 clocks and `d` is bits 15:6. In each period the output is high for exactly `d` clocks.
- R5: Control bits 3:2 place the pulse. With 0, it is high on counts 0 to d-1. With 1, it is high on counts P-d to P-1. With 2, it is high from count floor((P-d)/2) for d clocks. Code 3 behaves as 0.
- R6: When control bit 14 is 1, sample bit 15 is inverted before use, so two's-complement input becomes offset binary. When bit 14 is 0, the sample is used unchanged.
- R7: Control bits 17:15 shift the (possibly inverted) 16-bit sample left by 0 to 7 places. Bits shifted past bit 15 are lost.
- R8: A write with `reg_wide_i`=1 carries the left sample in bits 15:0, which drives `pwm_o[0]`, and the right sample in bits 31:16, which drives `pwm_o[1]`. A write with `reg_wide_i`=0 uses bits 15:0 for both channels.
- R9: A sample write is accepted only while `smp_ready_o` is 1. After an accepted write, `smp_ready_o` is 0 on the next cycle. A sample write made while it is 0 is dropped.
- R10: A held pair becomes active only at the end of period number rep+1 of the current sample, where rep is control bits 12:4, or on the next clock while disabled. `smp_ready_o` returns to 1 at that point.
- R11: When no new pair is held at a sample boundary, the active pair continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | PWM and bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wide_i | input | 1 | 1: 32-bit stereo sample write, 0: 16-bit mono write |
| reg_addr_i | input | 4 | Register byte offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the addressed register |
| smp_ready_o | output | 1 | Holding register empty |
| pwm_o | output | 2 | PWM bit streams, bit 0 left, bit 1 right |

## Verification
The hardest situation to reach is a handover while the block is running. A pair is held while an older pair is still being repeated, and a second write arrives and must be dropped. The bench loads the first pair while the block is disabled and enables it with a repeat count of three periods. It then writes a second pair at once and a third pair right after. The scoreboard expects three periods of the first pair followed by the second pair repeating, with the third pair never appearing. Ready is checked as low in the middle of the run and as high after the boundary.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;

  typedef enum logic [1:0] {
    ALIGN_LEFT   = 2'd0,
    ALIGN_RIGHT  = 2'd1,
    ALIGN_CENTRE = 2'd2,
    ALIGN_RSVD   = 2'd3
  } align_e;

  // bit positions follow the control word layout: en at bit 0, shift at 17:15
  typedef struct packed {
    logic [2:0] shift;
    logic       msb_inv;
    logic       chg;
    logic [8:0] rep_m1;
    align_e     align;
    logic       res10;
    logic       en;
  } ctrl_t;

  localparam int          CTRL_W   = $bits(ctrl_t);
  localparam int          REP_W    = 9;
  localparam logic [31:0] CTRL_RST = 32'h0000_4008;

endpackage

// File: rtl/pwm_dac_regs.sv
module pwm_dac_regs
  import pwm_dac_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BUS_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output ctrl_t             ctrl_o,
  output logic              smp_we_o
);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(4);

  ctrl_t ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= ctrl_t'(CTRL_RST[CTRL_W-1:0]);
    else if (we_i && addr_i == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i);
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL) rdata_o = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q};
  end

  assign ctrl_o   = ctrl_q;
  assign smp_we_o = we_i && (addr_i == ADDR_DATA);
endmodule

// File: rtl/pwm_dac_seq.sv
module pwm_dac_seq
  import pwm_dac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_CH   = 2,
  parameter int CNT_W  = 10,
  parameter int LO_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       en_i,
  input  logic                       res10_i,
  input  logic [REP_W-1:0]           rep_m1_i,
  input  logic                       smp_we_i,
  input  logic                       wide_i,
  input  logic [N_CH*DATA_W-1:0]     wdata_i,
  output logic                       ready_o,
  output logic                       wrap_o,
  output logic [CNT_W-1:0]           cnt_o,
  output logic [N_CH-1:0][DATA_W-1:0] smp_o
);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'((1 << LO_W) - 1);
  localparam logic [CNT_W-1:0] LAST_HI = {CNT_W{1'b1}};

  logic [N_CH-1:0][DATA_W-1:0] hold_q, act_q;
  logic                        full_q;
  logic [CNT_W-1:0]            cnt_q;
  logic [REP_W-1:0]            rep_q;
  logic [CNT_W-1:0]            last;
  logic                        wrap, seg_end, load, accept;

  assign last    = res10_i ? LAST_HI : LAST_LO;
  assign wrap    = en_i && (cnt_q >= last);
  assign seg_end = wrap && (rep_q == rep_m1_i);
  assign load    = full_q && (!en_i || seg_end);
  assign accept  = smp_we_i && !full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rep_q <= '0;
    end else if (!en_i) begin
      cnt_q <= '0;
      rep_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      rep_q <= seg_end ? '0 : rep_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else if (accept) full_q <= 1'b1;
    else if (load) full_q <= 1'b0;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    // narrow writes feed every channel from the low lane
    logic [DATA_W-1:0] lane;
    assign lane = wide_i ? wdata_i[ch*DATA_W +: DATA_W] : wdata_i[DATA_W-1:0];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hold_q[ch] <= '0;
        act_q[ch]  <= '0;
      end else begin
        if (accept) hold_q[ch] <= lane;
        if (load) act_q[ch] <= hold_q[ch];
      end
    end
  end

  assign ready_o = !full_q;
  assign wrap_o  = wrap;
  assign cnt_o   = cnt_q;
  assign smp_o   = act_q;
endmodule

// File: rtl/pwm_dac_chan.sv
module pwm_dac_chan
  import pwm_dac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 10,
  parameter int LO_W   = 8,
  parameter int SH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              res10_i,
  input  align_e            align_i,
  input  logic              msb_inv_i,
  input  logic [SH_W-1:0]   shift_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              pwm_o
);
  localparam int PW = CNT_W + 1;
  localparam logic [PW-1:0] PER_LO = PW'(1 << LO_W);
  localparam logic [PW-1:0] PER_HI = PW'(1 << CNT_W);

  logic [DATA_W-1:0] flipped, conv;
  logic [PW-1:0]     duty, per, cnt, start;
  logic              hit, pwm_q;

  assign flipped = smp_i ^ {msb_inv_i, {(DATA_W-1){1'b0}}};
  assign conv    = flipped << shift_i;
  assign duty    = res10_i ? PW'(conv[DATA_W-1 -: CNT_W]) : PW'(conv[DATA_W-1 -: LO_W]);
  assign per     = res10_i ? PER_HI : PER_LO;
  assign cnt     = PW'(cnt_i);
  assign start   = (per - duty) >> 1;

  always_comb begin
    unique case (align_i)
      ALIGN_RIGHT:  hit = cnt >= (per - duty);
      ALIGN_CENTRE: hit = (cnt >= start) && (cnt < start + duty);
      default:      hit = cnt < duty;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else pwm_q <= en_i && hit;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
  import pwm_dac_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int N_CH   = 2,
  parameter int CNT_W  = 10,
  parameter int LO_W   = 8,
  parameter int ADDR_W = 4,
  localparam int BUS_W = N_CH * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic              reg_wide_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              smp_ready_o,
  output logic [N_CH-1:0]   pwm_o
);
  ctrl_t                       ctrl;
  logic                        smp_we;
  logic                        wrap_w;
  logic [CNT_W-1:0]            cnt_w;
  logic [N_CH-1:0][DATA_W-1:0] act;
  logic                        en_w, res10_w;

  assign en_w    = ctrl.en;
  assign res10_w = ctrl.res10;

  pwm_dac_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i[CTRL_W-1:0]),
    .rdata_o  (reg_rdata_o),
    .ctrl_o   (ctrl),
    .smp_we_o (smp_we)
  );

  pwm_dac_seq #(.DATA_W(DATA_W), .N_CH(N_CH), .CNT_W(CNT_W), .LO_W(LO_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_w),
    .res10_i  (res10_w),
    .rep_m1_i (ctrl.rep_m1),
    .smp_we_i (smp_we),
    .wide_i   (reg_wide_i),
    .wdata_i  (reg_wdata_i),
    .ready_o  (smp_ready_o),
    .wrap_o   (wrap_w),
    .cnt_o    (cnt_w),
    .smp_o    (act)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_pwm
    pwm_dac_chan #(.DATA_W(DATA_W), .CNT_W(CNT_W), .LO_W(LO_W), .SH_W(3)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_w),
      .res10_i   (res10_w),
      .align_i   (ctrl.align),
      .msb_inv_i (ctrl.msb_inv),
      .shift_i   (ctrl.shift),
      .smp_i     (act[ch]),
      .cnt_i     (cnt_w),
      .pwm_o     (pwm_o[ch])
    );
  end
endmodule

// File: rtl/pwm_audio_dac_chk.sv
module pwm_audio_dac_chk #(
  parameter int N_CH   = 2,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              smp_ready_o,
  input logic [N_CH-1:0]   pwm_o,
  input logic              en_w,
  input logic              wrap_w,
  input logic [CNT_W-1:0]  cnt_w
);
  AST_ACCEPT_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && reg_addr_i == '0 && smp_ready_o |=> !smp_ready_o); // R9

  AST_FREE_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(smp_ready_o) |-> $past(!en_w || wrap_w)); // R10

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_w |=> pwm_o == '0); // R3

  AST_PERIOD_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_w |=> cnt_w == '0); // R4
endmodule

bind pwm_audio_dac pwm_audio_dac_chk #(.N_CH(N_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .smp_ready_o (smp_ready_o),
  .pwm_o       (pwm_o),
  .en_w        (en_w),
  .wrap_w      (wrap_w),
  .cnt_w       (cnt_w)
);

// File: tb/pwm_audio_dac_tb.sv
module pwm_audio_dac_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic        reg_wide_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        smp_ready_o;
  logic [1:0]  pwm_o;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  pwm_audio_dac u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_wide_i  (reg_wide_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .smp_ready_o (smp_ready_o),
    .pwm_o       (pwm_o)
  );

  typedef struct {
    int    per;
    int    st_l, w_l, st_r, w_r;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   mon_go = 0;
  bit   mon_done = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input bit wide);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; reg_wide_i = wide;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  // reference from the requirements: period, duty and pulse start
  task automatic model(input logic [31:0] ctrl, input logic [15:0] s, output int per, output int st, output int w);
    logic [15:0] v;
    v = s ^ {ctrl[14], 15'd0};
    v = v << ctrl[17:15];
    per = ctrl[1] ? 1024 : 256;
    w = ctrl[1] ? int'(v[15:6]) : int'(v[15:8]);
    case (ctrl[3:2])
      2'd1:    st = per - w;
      2'd2:    st = (per - w) / 2;
      default: st = 0;
    endcase
    if (w == 0) st = per;
  endtask

  task automatic push(input logic [31:0] ctrl, input logic [31:0] d, input bit wide, input int n, input string tag);
    exp_t e;
    logic [15:0] rs;
    rs = wide ? d[31:16] : d[15:0];
    model(ctrl, d[15:0], e.per, e.st_l, e.w_l);
    model(ctrl, rs, e.per, e.st_r, e.w_r);
    e.tag = tag;
    for (int i = 0; i < n; i++) exp_q.push_back(e);
  endtask

  // monitor: measures each period on both outputs and pops the expectation
  initial begin
    forever begin
      wait (mon_go);
      mon_go = 0;
      @(posedge clk_i);
      while (exp_q.size() > 0) begin
        exp_t e;
        int fl, fr, wl, wr;
        e = exp_q.pop_front();
        fl = e.per; fr = e.per; wl = 0; wr = 0;
        for (int j = 0; j < e.per; j++) begin
          @(negedge clk_i);
          if (pwm_o[0]) begin wl++; if (fl == e.per) fl = j; end
          if (pwm_o[1]) begin wr++; if (fr == e.per) fr = j; end
        end
        check(fl == e.st_l && wl == e.w_l, {e.tag, " left start/width"},
              {fl[15:0], wl[15:0]}, {e.st_l[15:0], e.w_l[15:0]});
        check(fr == e.st_r && wr == e.w_r, {e.tag, " right start/width"},
              {fr[15:0], wr[15:0]}, {e.st_r[15:0], e.w_r[15:0]});
      end
      mon_done = 1;
    end
  end

  task automatic run_case(input logic [31:0] ctrl, input logic [31:0] d, input bit wide, input int n, input string tag);
    bus_write(4'h4, ctrl & ~32'h1, 1'b1);
    bus_write(4'h0, d, wide);
    repeat (2) @(negedge clk_i);
    push(ctrl, d, wide, n, tag);
    bus_write(4'h4, ctrl | 32'h1, 1'b1);
    mon_go = 1;
    wait (mon_done);
    mon_done = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    bus_read(4'h4, rd);
    check(rd == 32'h0000_4008, "R1 ctrl reset", rd, 32'h0000_4008);
    bus_read(4'h0, rd);
    check(rd == 32'h0, "R1 data reads zero", rd, 32'h0);
    check(smp_ready_o == 1'b1, "R1 ready after reset", {31'd0, smp_ready_o}, 32'h1);
    check(pwm_o == 2'b00, "R1 outputs low", {30'd0, pwm_o}, 32'h0);

    // R2 readback incl. change flag, upper bits dropped
    bus_write(4'h4, 32'hFFFC_A55A, 1'b1);
    bus_read(4'h4, rd);
    check(rd == (32'hFFFC_A55A & 32'h3FFFF), "R2 ctrl readback", rd, 32'hFFFC_A55A & 32'h3FFFF);

    // R4 R5 R8 left-aligned stereo, 8-bit
    run_case(32'h0000_0000, 32'hC000_4000, 1'b1, 2, "R5 left R8 stereo");
    // R5 right-aligned, zero duty on left
    run_case(32'h0000_0004, 32'hFF00_0000, 1'b1, 2, "R5 right");
    // R6 R5 centre with MSB flip
    run_case(32'h0000_4008, 32'hFFFF_0000, 1'b1, 2, "R6 centre");
    // R4 R7 10-bit with shift 2, top bits lost
    run_case(32'h0001_0002, 32'h3FFF_1234, 1'b1, 2, "R7 R4 10-bit shift");
    // R8 narrow write feeds both channels
    run_case(32'h0000_0000, 32'h00AB_2000, 1'b0, 2, "R8 mono");

    // R3 disable forces outputs low
    bus_write(4'h4, 32'h0, 1'b1);
    @(negedge clk_i);
    check(pwm_o == 2'b00, "R3 disabled low", {30'd0, pwm_o}, 32'h0);

    // R9 R10 R11 handover during repeat, second write dropped
    bus_write(4'h4, 32'h0000_0020, 1'b1);
    bus_write(4'h0, 32'h8000_4000, 1'b1);
    repeat (2) @(negedge clk_i);
    push(32'h0000_0020, 32'h8000_4000, 1'b1, 3, "R10 old pair held");
    push(32'h0000_0020, 32'h2000_6000, 1'b1, 6, "R11 new pair repeats");
    bus_write(4'h4, 32'h0000_0021, 1'b1);
    mon_go = 1;
    bus_write(4'h0, 32'h2000_6000, 1'b1);
    check(smp_ready_o == 1'b0, "R9 ready drops", {31'd0, smp_ready_o}, 32'h0);
    bus_write(4'h0, 32'hF000_F000, 1'b1);
    repeat (300) @(negedge clk_i);
    check(smp_ready_o == 1'b0, "R10 held until boundary", {31'd0, smp_ready_o}, 32'h0);
    wait (mon_done);
    mon_done = 0;
    check(smp_ready_o == 1'b1, "R10 ready after boundary", {31'd0, smp_ready_o}, 32'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule